// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits between a host and an asynchronous parallel NOR flash and turns single read requests into bus cycles on the flash pins. It keeps an 8-word page open for as long as chip enable stays low. A later read that lands in the open page, in the same width mode, waits only the short in-page access count. Any other read waits the full initial access count. Writes and erase are not handled. Write enable is always held high, and the flash is read directly from reset with no command sequence first.

Reads arrive on a valid/ready port. The host holds `req_valid`, `req_addr` and `req_byte` stable until a cycle in which `req_ready` is high. That cycle is the handshake. `req_ready` is low while an access is in flight and while `close_req` is high, and this is the only back-pressure. The result comes back as a single-cycle `rsp_valid` pulse. The response side has no ready, so the host must take the data in that cycle.

Two wait counts set the access times: `t_init` for a page miss and `t_page` for a page hit. Both are counted in clock cycles, and a value of zero acts as one. Chip enable drops, and the open page is forgotten, in two cases: after `IDLE_CYC` idle cycles with no accepted request, or when `close_req` is raised.

Top module: `pgflash_rd_ctrl`

## Requirements
- R1: Out of reset: `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, `req_ready` is high, `rsp_valid` is low, no page is open, and the first request is served without any command.
- R2: `fl_we_n` is always high. During every access-wait cycle both `fl_ce_n` and `fl_oe_n` are low. `fl_oe_n` is high in all other cycles.
- R3: Word mode (`req_byte`=0) drives `fl_addr = req_addr[ADDR_W-1:0]` and `fl_addr_lsb = 0`. Byte mode drives `fl_addr = req_addr[ADDR_W:1]` and `fl_addr_lsb = req_addr[0]`. The address is held stable for the whole wait.
- R4: A page miss keeps `fl_oe_n` low for exactly `t_init` cycles after the handshake. `rsp_valid` is high in the cycle after the last of them.
- R5: A hit keeps `fl_oe_n` low for exactly `t_page` cycles. A read is a hit when a page is open, the mode matches the mode that opened it, and the page tag matches. The page tag is `req_addr[ADDR_W-1:3]` in word mode and `req_addr[ADDR_W:4]` in byte mode.
- R6: Once `fl_ce_n` has gone high, the next read is a miss, even if it falls in the same page.
- R7: After `IDLE_CYC` consecutive cycles in which chip enable is asserted and no access is waiting and none is accepted, `fl_ce_n` goes high and the page closes.
- R8: While `close_req` is high and no access is waiting, `req_ready` is low. `fl_ce_n` is high from the next cycle on, and the page closes.
- R9: `rsp_valid` lasts exactly one cycle. `rsp_data` is the data bus sampled at the end of the last wait cycle. In byte mode it is zero-extended from `fl_dq_in[7:0]`.
- R10: A `t_init` or `t_page` value of 0 behaves as 1.
- R11: `req_ready` is low from the handshake until the response cycle. A request held during that time is not taken.
- R12: A read whose mode differs from the mode of the open page is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| t_init | input | CNT_W | miss access wait, cycles |
| t_page | input | CNT_W | in-page access wait, cycles |
| close_req | input | 1 | request to release the flash (non-read operation pending) |
| req_valid | input | 1 | read request valid |
| req_ready | output | 1 | read request accepted when high with valid |
| req_addr | input | ADDR_W+1 | word address (word mode) or byte address (byte mode) |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| rsp_valid | output | 1 | one-cycle response strobe |
| rsp_data | output | DATA_W | read data |
| fl_ce_n | output | 1 | flash chip enable, active low |
| fl_oe_n | output | 1 | flash output enable, active low |
| fl_we_n | output | 1 | flash write enable, held high |
| fl_addr | output | ADDR_W | flash address bits |
| fl_addr_lsb | output | 1 | extra low address bit used in byte mode |
| fl_dq_in | input | DATA_W | flash data bus |

## Verification
The bench builds the block with ADDR_W=12, DATA_W=16 and CNT_W=4. It sets IDLE_CYC to 6, so the idle timeout can be reached and crossed within a few cycles. Wait counts of 5 and 2 give miss and hit latencies that are clearly different. A later pass with both counts at 0 exercises the minimum one-cycle wait. With 12 address bits, word and byte requests can target the same numeric tag, so a mode change alone can be shown to force a miss.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [0:0] {
    ACC_IDLE = 1'b0,
    ACC_WAIT = 1'b1
  } acc_state_t;
endpackage

// File: rtl/fpr_page_track.sv
module fpr_page_track #(
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             mode_i,
  output logic             hit_o
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  logic             mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      mode_q <= 1'b0;
    end else if (open_i) begin
      vld_q  <= 1'b1;
      tag_q  <= tag_i;
      mode_q <= mode_i;
    end else if (close_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign hit_o = vld_q && (tag_q == tag_i) && (mode_q == mode_i);

  // R6: a page that was closed cannot produce a hit in the next cycle
  a_r6_closed_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    close_i && !open_i |=> !hit_o);
endmodule

// File: rtl/fpr_wait_timer.sv
module fpr_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last_o = (cnt_q == '0);

  // R10: the wait length handed in is never zero
  a_r10_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> len_i != '0);
endmodule

// File: rtl/fpr_idle_timer.sv
module fpr_idle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic expire_o
);
  localparam int IW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [IW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == IW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!tick_i || expire_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + IW'(1);
    end
  end
endmodule

// File: rtl/pgflash_rd_ctrl.sv
module pgflash_rd_ctrl
  import fpr_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 6,
  parameter int IDLE_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  t_init,
  input  logic [CNT_W-1:0]  t_page,
  input  logic              close_req,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_byte,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_addr_lsb,
  input  logic [DATA_W-1:0] fl_dq_in
);
  localparam int TAG_W = ADDR_W - 3;

  acc_state_t        st_q;
  logic              byte_q;
  logic              accept;
  logic              hit;
  logic              last;
  logic              idle_tick;
  logic              idle_exp;
  logic              page_close;
  logic [TAG_W-1:0]  req_tag;
  logic [CNT_W-1:0]  init_eff;
  logic [CNT_W-1:0]  page_eff;
  logic [CNT_W-1:0]  wait_len;
  logic [DATA_W-1:0] dq_fmt;

  assign fl_we_n   = 1'b1;
  assign req_ready = (st_q == ACC_IDLE) && !close_req;
  assign accept    = req_valid && req_ready;
  assign req_tag   = req_byte ? req_addr[ADDR_W:4] : req_addr[ADDR_W-1:3];
  assign init_eff  = (t_init == '0) ? CNT_W'(1) : t_init;
  assign page_eff  = (t_page == '0) ? CNT_W'(1) : t_page;
  assign wait_len  = hit ? page_eff : init_eff;

  assign idle_tick  = (st_q == ACC_IDLE) && !fl_ce_n && !accept && !close_req;
  assign page_close = (st_q == ACC_IDLE) && (close_req || idle_exp);

  always_comb begin
    dq_fmt = fl_dq_in;
    if (byte_q) begin
      dq_fmt      = '0;
      dq_fmt[7:0] = fl_dq_in[7:0];
    end
  end

  fpr_page_track #(.TAG_W(TAG_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_i  (accept),
    .close_i (page_close),
    .tag_i   (req_tag),
    .mode_i  (req_byte),
    .hit_o   (hit)
  );

  fpr_wait_timer #(.CNT_W(CNT_W)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .len_i  (wait_len),
    .last_o (last)
  );

  fpr_idle_timer #(.LIMIT(IDLE_CYC)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (idle_tick),
    .expire_o (idle_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ACC_IDLE;
      fl_ce_n     <= 1'b1;
      fl_oe_n     <= 1'b1;
      fl_addr     <= '0;
      fl_addr_lsb <= 1'b0;
      byte_q      <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st_q)
        ACC_IDLE: begin
          if (accept) begin
            st_q    <= ACC_WAIT;
            fl_ce_n <= 1'b0;
            fl_oe_n <= 1'b0;
            byte_q  <= req_byte;
            if (req_byte) begin
              fl_addr     <= req_addr[ADDR_W:1];
              fl_addr_lsb <= req_addr[0];
            end else begin
              fl_addr     <= req_addr[ADDR_W-1:0];
              fl_addr_lsb <= 1'b0;
            end
          end else if (page_close) begin
            fl_ce_n <= 1'b1;
          end
        end
        ACC_WAIT: begin
          if (last) begin
            st_q      <= ACC_IDLE;
            fl_oe_n   <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_data  <= dq_fmt;
          end
        end
        default: st_q <= ACC_IDLE;
      endcase
    end
  end

  // R2: output enable only ever low with chip enable low
  a_r2_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_ce_n);
  // R3: address stays put while the access waits
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |=> fl_oe_n || ($stable(fl_addr) && $stable(fl_addr_lsb)));
  // R9: response strobe is one cycle wide
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9: response follows the end of a wait
  a_r9_rsp_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(fl_oe_n));
  // R11: no new request taken while waiting
  a_r11_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !req_ready);
  // R8: close request releases chip enable in the next cycle
  a_r8_close_ce: assert property (@(posedge clk) disable iff (!rst_n)
    close_req && fl_oe_n |=> fl_ce_n);
endmodule

// File: tb/tb_pgflash_rd_ctrl.sv
module tb_pgflash_rd_ctrl;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int IDLE = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] t_init = 4'd5;
  logic [CW-1:0] t_page = 4'd2;
  logic          close_req = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW:0]   req_addr = '0;
  logic          req_byte = 1'b0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          fl_ce_n, fl_oe_n, fl_we_n, fl_addr_lsb;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_in;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] flash_word(input logic [AW-1:0] a, input logic l);
    return {a[7:0] ^ 8'hA5, a[6:0] ^ 7'h2B, l};
  endfunction

  assign fl_dq_in = flash_word(fl_addr, fl_addr_lsb);

  pgflash_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .IDLE_CYC(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .t_init(t_init), .t_page(t_page),
    .close_req(close_req), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_addr_lsb(fl_addr_lsb),
    .fl_dq_in(fl_dq_in)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit  m_busy, m_open, m_mode, m_ce, m_rv, m_lsb;
  int  m_left, m_tag, m_idle, m_addr;
  logic [DW-1:0] m_rd;

  function automatic int tag_of(input logic [AW:0] a, input logic b);
    return b ? int'(a >> 4) : int'(a[AW-1:0] >> 3);
  endfunction

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_open = 0; m_mode = 0; m_ce = 0; m_rv = 0; m_lsb = 0;
      m_left = 0; m_tag = 0; m_idle = 0; m_addr = 0; m_rd = '0;
    end else begin
      m_rv = 0;
      if (m_busy) begin
        if (m_left == 1) begin
          m_busy = 0; m_rv = 1; m_idle = 0;
          m_rd = m_mode ? {8'h00, flash_word(AW'(m_addr), m_lsb)[7:0]}
                        : flash_word(AW'(m_addr), 1'b0);
        end else m_left--;
      end else if (close_req) begin
        m_ce = 0; m_open = 0; m_idle = 0;
      end else if (req_valid) begin
        bit hit;
        hit = m_open && m_tag == tag_of(req_addr, req_byte) && m_mode == req_byte;
        m_left = hit ? eff(t_page) : eff(t_init);
        m_busy = 1; m_ce = 1; m_open = 1; m_idle = 0;
        m_tag = tag_of(req_addr, req_byte); m_mode = req_byte;
        m_addr = req_byte ? int'(req_addr >> 1) : int'(req_addr[AW-1:0]);
        m_lsb = req_byte ? req_addr[0] : 1'b0;
      end else if (m_ce) begin
        if (m_idle == IDLE - 1) begin
          m_ce = 0; m_open = 0; m_idle = 0;
        end else m_idle++;
      end
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      check("R2 R6 R7 R8 ce_n", fl_ce_n, !m_ce);
      check("R2 R4 R5 oe_n", fl_oe_n, !m_busy);
      check("R2 we_n", fl_we_n, 1'b1);
      check("R8 R11 ready", req_ready, !m_busy && !close_req);
      check("R9 rsp_valid", rsp_valid, m_rv);
      if (m_rv) check("R9 rsp_data", rsp_data, m_rd);
      if (m_busy) begin
        check("R3 addr", fl_addr, AW'(m_addr));
        check("R3 lsb", fl_addr_lsb, m_lsb);
      end
    end
  end

  task automatic do_read(input logic [AW:0] a, input logic b, input int exp_lat,
                         input string req);
    int lat;
    logic [DW-1:0] exp_d;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_byte = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 ready low after handshake", req_ready, 1'b0);
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(req, lat, exp_lat);
    exp_d = b ? {8'h00, flash_word(a[AW:1], a[0])[7:0]} : flash_word(a[AW-1:0], 1'b0);
    check("R9 data", rsp_data, exp_d);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    check("R1 ce_n reset", fl_ce_n, 1'b1);
    check("R1 oe_n reset", fl_oe_n, 1'b1);
    check("R1 ready reset", req_ready, 1'b1);
    check("R1 rsp reset", rsp_valid, 1'b0);
    rst_n = 1'b1;
    do_read(13'h010, 1'b0, 6, "R1 R4 first read miss");
    do_read(13'h013, 1'b0, 3, "R5 hit");
    do_read(13'h018, 1'b0, 6, "R4 new page miss");
    do_read(13'h01F, 1'b0, 3, "R5 hit top word");
    @(negedge clk); close_req = 1'b1;
    #1 check("R8 ready low on close", req_ready, 1'b0);
    @(negedge clk); close_req = 1'b0;
    check("R8 ce released", fl_ce_n, 1'b1);
    do_read(13'h01A, 1'b0, 6, "R6 R8 reopen miss");
    repeat (IDLE + 3) @(negedge clk);
    check("R7 idle release", fl_ce_n, 1'b1);
    do_read(13'h01B, 1'b0, 6, "R7 miss after timeout");
    repeat (2) @(negedge clk);
    do_read(13'h01C, 1'b0, 3, "R7 hit before timeout");
    do_read(13'h039, 1'b1, 6, "R12 mode change miss");
    do_read(13'h038, 1'b1, 3, "R5 R3 byte hit");
    do_read(13'h03E, 1'b1, 3, "R5 byte hit upper");
    t_init = 4'd0; t_page = 4'd0;
    do_read(13'h200, 1'b0, 2, "R10 zero init");
    do_read(13'h201, 1'b0, 2, "R10 zero page");
    t_init = 4'd3; t_page = 4'd1;
    do_read(13'h208, 1'b0, 4, "R4 miss t_init 3");
    do_read(13'h20D, 1'b0, 2, "R5 hit t_page 1");
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule